// File: doc/BRIEF.md
# Serial Flash Read Bridge

This block lets an on-chip bus master read from up to two external serial flash or EEPROM devices as if they were plain memory. A read request carries a 25-bit bus address and an access size of one, two or four bytes. The bridge turns it into a serial read transaction. It acts only as the serial master: it drives the serial clock, the data-out line and two active-low chip selects, and it samples the data-in line. The requested bytes come back packed into a 32-bit word, together with a one-cycle ready pulse.

Address bit 24 picks the device, and bits 23:0 are the byte address inside that device's 16 MB window. The serial clock is made from the bus clock by a 7-bit divider. Two read flavours are available. The plain read sends command 0x03. The fast read sends command 0x0B and then inserts eight dummy clocks before any data is captured. Divider and read flavour come from configuration inputs that some register outside this block drives. Both values are captured when a request is accepted.

The sequencer moves through these states. IDLE waits for a request. CMD shifts out the command byte. ADDR shifts out the 24-bit address. DUMMY, used in fast mode only, runs eight clocks with the data-out line low. DATA captures the data bytes. DONE is a single cycle that releases the chip select and raises ready. GAP holds the chip select high for one full serial clock period before the sequencer returns to IDLE. The transitions are:
- IDLE to CMD when a request is present.
- CMD to ADDR after 8 bits.
- ADDR to DUMMY (fast mode) or to DATA (plain mode) after 24 bits.
- DUMMY to DATA after 8 bits.
- DATA to DONE after the last data bit.
- DONE to GAP unconditionally.
- GAP to IDLE after two divider ticks.

Top module: `sflash_read_bridge`

## Requirements
- R1: Bus address bit 24 equal to 0 asserts chip select 0 (`sf_cs_n[0]` low); equal to 1 it asserts chip select 1. At most one chip select is low at any time, and the bridge only ever drives the serial clock and chip selects, never samples them.
- R2: In plain mode the device sees command byte 0x03, then address bits 23:0, MSB first, on 32 consecutive rising clock edges; data capture starts on the very next rising edge.
- R3: In fast mode the device sees command byte 0x0B, then the 24-bit address, then 8 dummy rising edges (40 header edges) before data capture starts.
- R4: With divider value N (1 to 127, with 0 behaving as 1) each serial clock phase lasts N bus clocks, so rising edges are 2N bus clocks apart. The serial clock idles low while no chip select is asserted. Divider and mode are captured at request acceptance; later changes do not affect the running transaction.
- R5: SPI mode 0: data-out changes only while the serial clock is low, and data-in is sampled on rising edges.
- R6: Size encoding on `bus_size`: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. The data phase has exactly 8 rising edges per byte.
- R7: Data bytes are packed little-endian: the byte from device address A+k lands in `bus_rdata[8k+7:8k]`. Unrequested upper bytes read as zero.
- R8: `bus_ready` is high for exactly one bus cycle per transaction, and `bus_rdata` is valid in that cycle.
- R9: The bridge accepts a request only in IDLE. Address, size and configuration changes during a transaction, including in the ready cycle, are ignored. Between two transactions the chip selects all stay high for at least 2N bus clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 7 | Serial clock divider, 0 treated as 1 |
| cfg_fast | input | 1 | 1 selects fast read with dummy clocks |
| bus_req | input | 1 | Read request, held until accepted |
| bus_addr | input | 25 | Bit 24 device select, bits 23:0 byte address |
| bus_size | input | 2 | Access size code |
| bus_ready | output | 1 | One-cycle data-valid pulse |
| bus_rdata | output | 32 | Packed read data |
| sf_sck | output | 1 | Serial clock, idles low |
| sf_mosi | output | 1 | Serial data to the devices |
| sf_cs_n | output | 2 | Active-low chip selects |
| sf_miso | input | 1 | Serial data from the devices |

## Verification
The ready pulse and the arrival of the next request can fall in the same bus cycle. The bench provokes this by keeping the request line high through the ready cycle and switching it to a new address in that same cycle. It then judges that the first transaction's data is unaffected, that the second transaction carries the new address, and that the chip selects stayed high for at least 2N bus clocks in between. A second coincidence is a divider and address change landing mid-transaction. The bench injects this as soon as the chip select falls and expects the edge spacing and header of the original request.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_DONE,
        ST_GAP
    } sfr_state_e;

    localparam logic [7:0] OP_PLAIN_READ = 8'h03;
    localparam logic [7:0] OP_FAST_READ  = 8'h0B;
    localparam int         DUMMY_BITS    = 8;

endpackage

// File: rtl/sfr_tick_gen.sv
module sfr_tick_gen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_eff;

    always_comb begin
        div_eff = (div == '0) ? DIV_W'(1) : div;
        tick    = run && (cnt_q == div_eff - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < div_eff);

endmodule

// File: rtl/sfr_rx_pack.sv
module sfr_rx_pack #(
    parameter int DATA_BYTES = 4,
    parameter int BIT_W      = $clog2(DATA_BYTES * 8)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    smp,
    input  logic [BIT_W-1:0]        bit_idx,
    input  logic                    din,
    output logic [DATA_BYTES*8-1:0] word
);

    logic [6:0] part_q;
    logic       byte_end;

    assign byte_end = smp && (bit_idx[2:0] == 3'b111);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_q <= '0;
        end else if (clr) begin
            part_q <= '0;
        end else if (smp) begin
            part_q <= {part_q[5:0], din};
        end
    end

    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (clr) begin
                lane_q <= '0;
            end else if (byte_end && (bit_idx[BIT_W-1:3] == (BIT_W-3)'(g))) begin
                lane_q <= {part_q, din};
            end
        end
        assign word[8*g +: 8] = lane_q;
    end

    // R7
    pack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (word == '0));

endmodule

// File: rtl/sfr_seq.sv
module sfr_seq
    import sfr_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DIV_W      = 7,
    parameter int DATA_BYTES = 4,
    parameter int BIT_W      = $clog2(DATA_BYTES * 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [ADDR_W:0]  addr,
    input  logic [1:0]       size,
    input  logic [DIV_W-1:0] div_in,
    input  logic             fast_in,
    input  logic             tick,
    output logic [DIV_W-1:0] div_q,
    output logic             run,
    output logic             sck,
    output logic             mosi,
    output logic [1:0]       cs_n,
    output logic             ready,
    output logic             pack_clr,
    output logic             pack_smp,
    output logic [BIT_W-1:0] bit_idx
);

    localparam int TX_W     = 8 + ADDR_W;
    localparam int MAX_PH   = (ADDR_W > DATA_BYTES * 8) ? ADDR_W : DATA_BYTES * 8;
    localparam int CNT_W    = $clog2(MAX_PH);

    sfr_state_e        state_q, state_d;
    logic [TX_W-1:0]   tx_q;
    logic [CNT_W-1:0]  bit_q;
    logic [1:0]        size_q;
    logic              sel_q;
    logic              fast_q;
    logic              sck_q;
    logic              gap_q;
    logic              in_xfer;
    logic              accept;
    logic              rise;
    logic              fall;
    logic              phase_last;
    logic [CNT_W:0]    phase_len;

    always_comb begin
        in_xfer = (state_q == ST_CMD) || (state_q == ST_ADDR) ||
                  (state_q == ST_DUMMY) || (state_q == ST_DATA);
        accept  = (state_q == ST_IDLE) && req;
        rise    = tick && in_xfer && !sck_q;
        fall    = tick && in_xfer && sck_q;
        unique case (state_q)
            ST_CMD:   phase_len = (CNT_W+1)'(8);
            ST_ADDR:  phase_len = (CNT_W+1)'(ADDR_W);
            ST_DUMMY: phase_len = (CNT_W+1)'(DUMMY_BITS);
            ST_DATA:  phase_len = (size_q == 2'd0) ? (CNT_W+1)'(8) :
                                  (size_q == 2'd1) ? (CNT_W+1)'(16) :
                                                     (CNT_W+1)'(DATA_BYTES * 8);
            default:  phase_len = (CNT_W+1)'(1);
        endcase
        phase_last = ({1'b0, bit_q} == phase_len - 1'b1);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req) state_d = ST_CMD;
            ST_CMD:   if (fall && phase_last) state_d = ST_ADDR;
            ST_ADDR:  if (fall && phase_last) state_d = fast_q ? ST_DUMMY : ST_DATA;
            ST_DUMMY: if (fall && phase_last) state_d = ST_DATA;
            ST_DATA:  if (fall && phase_last) state_d = ST_DONE;
            ST_DONE:  state_d = ST_GAP;
            ST_GAP:   if (tick && gap_q) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            bit_q  <= '0;
            size_q <= '0;
            sel_q  <= 1'b0;
            fast_q <= 1'b0;
            div_q  <= DIV_W'(1);
            sck_q  <= 1'b0;
            gap_q  <= 1'b0;
        end else begin
            if (accept) begin
                tx_q   <= {(fast_in ? OP_FAST_READ : OP_PLAIN_READ), addr[ADDR_W-1:0]};
                sel_q  <= addr[ADDR_W];
                size_q <= size;
                fast_q <= fast_in;
                div_q  <= div_in;
                bit_q  <= '0;
                sck_q  <= 1'b0;
            end
            if (rise) begin
                sck_q <= 1'b1;
            end
            if (fall) begin
                sck_q <= 1'b0;
                tx_q  <= {tx_q[TX_W-2:0], 1'b0};
                bit_q <= phase_last ? '0 : bit_q + 1'b1;
            end
            if (state_q != ST_GAP) gap_q <= 1'b0;
            else if (tick)         gap_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        cs_n = 2'b11;
        if (in_xfer) cs_n[sel_q] = 1'b0;
        sck      = sck_q;
        mosi     = tx_q[TX_W-1];
        ready    = (state_q == ST_DONE);
        run      = in_xfer || (state_q == ST_GAP);
        pack_clr = accept;
        pack_smp = rise && (state_q == ST_DATA);
        bit_idx  = bit_q[BIT_W-1:0];
    end

    // R1
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R4
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> !sck);

    // R5
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R9
    gap_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |=> (&cs_n));

endmodule

// File: rtl/sflash_read_bridge.sv
module sflash_read_bridge #(
    parameter int ADDR_W     = 24,
    parameter int DIV_W      = 7,
    parameter int DATA_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DIV_W-1:0]        cfg_div,
    input  logic                    cfg_fast,
    input  logic                    bus_req,
    input  logic [ADDR_W:0]         bus_addr,
    input  logic [1:0]              bus_size,
    output logic                    bus_ready,
    output logic [DATA_BYTES*8-1:0] bus_rdata,
    output logic                    sf_sck,
    output logic                    sf_mosi,
    output logic [1:0]              sf_cs_n,
    input  logic                    sf_miso
);

    localparam int BIT_W = $clog2(DATA_BYTES * 8);

    logic [DIV_W-1:0] div_q;
    logic             run;
    logic             tick;
    logic             pack_clr;
    logic             pack_smp;
    logic [BIT_W-1:0] bit_idx;

    sfr_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div_q),
        .tick  (tick)
    );

    sfr_seq #(
        .ADDR_W     (ADDR_W),
        .DIV_W      (DIV_W),
        .DATA_BYTES (DATA_BYTES),
        .BIT_W      (BIT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (bus_req),
        .addr     (bus_addr),
        .size     (bus_size),
        .div_in   (cfg_div),
        .fast_in  (cfg_fast),
        .tick     (tick),
        .div_q    (div_q),
        .run      (run),
        .sck      (sf_sck),
        .mosi     (sf_mosi),
        .cs_n     (sf_cs_n),
        .ready    (bus_ready),
        .pack_clr (pack_clr),
        .pack_smp (pack_smp),
        .bit_idx  (bit_idx)
    );

    sfr_rx_pack #(
        .DATA_BYTES (DATA_BYTES),
        .BIT_W      (BIT_W)
    ) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pack_clr),
        .smp     (pack_smp),
        .bit_idx (bit_idx),
        .din     (sf_miso),
        .word    (bus_rdata)
    );

endmodule

// File: tb/test_sflash_read_bridge.sv
module test_sflash_read_bridge;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cfg_div = 7'd1;
    logic        cfg_fast = 1'b0;
    logic        bus_req = 1'b0;
    logic [24:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        sf_sck;
    logic        sf_mosi;
    logic [1:0]  sf_cs_n;
    logic        sf_miso = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    sflash_read_bridge i_sflash_read_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_div   (cfg_div),
        .cfg_fast  (cfg_fast),
        .bus_req   (bus_req),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .sf_sck    (sf_sck),
        .sf_mosi   (sf_mosi),
        .sf_cs_n   (sf_cs_n),
        .sf_miso   (sf_miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input bit chip, input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[19:16]} ^ (chip ? 8'hC3 : 8'h3C);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // device model, sampled away from the active clock edge
    int          hdr_len = 32;
    int          exp_n = 1;
    int          rises = 0;
    int          per_err = 0;
    int          cyc = 0;
    int          last_rise = -1;
    int          cs_rise_cyc = -100000;
    int          gap_seen = 100000;
    logic [31:0] hdr = '0;
    bit          chip_seen = 1'b0;
    bit          sck_prev = 1'b0;
    bit          act_prev = 1'b0;

    always @(negedge clk) begin
        bit act;
        cyc++;
        act = (sf_cs_n != 2'b11);
        if (act && !act_prev) begin
            rises     = 0;
            hdr       = '0;
            per_err   = 0;
            last_rise = -1;
            chip_seen = !sf_cs_n[1];
            gap_seen  = cyc - cs_rise_cyc;
        end
        if (!act && act_prev) cs_rise_cyc = cyc;
        if (act) begin
            if (sf_sck && !sck_prev) begin
                if (rises < 32) hdr = {hdr[30:0], sf_mosi};
                if (last_rise >= 0 && (cyc - last_rise) != 2 * exp_n) per_err++;
                last_rise = cyc;
                rises++;
            end
            if (!sf_sck && sck_prev && rises >= hdr_len) begin
                logic [7:0] b;
                b = mem_byte(chip_seen, hdr[23:0] + 24'((rises - hdr_len) / 8));
                sf_miso = b[7 - ((rises - hdr_len) % 8)];
            end
        end
        sck_prev = sf_sck;
        act_prev = act;
    end

    // one read; optionally disturbs inputs mid-transfer or queues a next request in the ready cycle
    task automatic do_read(input bit chip, input logic [23:0] a, input logic [1:0] sz,
                           input logic [6:0] pv, input bit fs, input bit poke,
                           input bit queue_next, input bit nchip, input logic [23:0] na,
                           input bit chk_gap);
        int  wait_cyc;
        int  nb;
        bit  poked;
        logic [31:0] exp_word;
        exp_n   = (pv == 0) ? 1 : int'(pv);
        hdr_len = fs ? 40 : 32;
        @(negedge clk); #1;
        cfg_div  = pv;
        cfg_fast = fs;
        bus_addr = {chip, a};
        bus_size = sz;
        bus_req  = 1'b1;
        wait_cyc = 0;
        poked    = 1'b0;
        do begin
            @(negedge clk); #1;
            wait_cyc++;
            if (poke && !poked && sf_cs_n != 2'b11) begin
                bus_addr = {~chip, ~a};
                bus_size = 2'd0;
                cfg_div  = pv + 7'd3;
                cfg_fast = ~fs;
                poked    = 1'b1;
            end
        end while (!bus_ready && wait_cyc < 8000);
        chk(bus_ready, "R8 ready timeout", 32'(wait_cyc), 32'd0);
        nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        exp_word = '0;
        for (int k = 0; k < nb; k++) exp_word[8*k +: 8] = mem_byte(chip, a + 24'(k));
        chk(bus_rdata == exp_word, "R7 packed data", bus_rdata, exp_word);
        if (fs) chk(hdr[31:24] == 8'h0B, "R3 fast command", 32'(hdr[31:24]), 32'h0B);
        else    chk(hdr[31:24] == 8'h03, "R2 plain command", 32'(hdr[31:24]), 32'h03);
        chk(hdr[23:0] == a, "R2 address", 32'(hdr[23:0]), 32'(a));
        chk(chip_seen == chip, "R1 chip select", 32'(chip_seen), 32'(chip));
        chk(rises == hdr_len + 8 * nb, "R6 edge count", 32'(rises), 32'(hdr_len + 8 * nb));
        chk(per_err == 0, "R4 edge spacing", 32'(per_err), 32'd0);
        if (chk_gap) chk(gap_seen >= 2 * exp_n, "R9 deselect gap", 32'(gap_seen), 32'(2 * exp_n));
        if (queue_next) begin
            bus_addr = {nchip, na};
        end else begin
            bus_req = 1'b0;
        end
        @(negedge clk); #1;
        chk(!bus_ready, "R8 single pulse", 32'(bus_ready), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [6:0] div_set [5] = '{7'd0, 7'd1, 7'd2, 7'd3, 7'd7};
        repeat (3) @(negedge clk);
        #1;
        chk(sf_cs_n == 2'b11, "R1 reset selects", 32'(sf_cs_n), 32'h3);
        chk(!sf_sck, "R4 reset clock low", 32'(sf_sck), 32'd0);
        chk(!bus_ready, "R8 reset ready", 32'(bus_ready), 32'd0);
        rst_n = 1'b1;

        // sweep divider x mode x size, alternating devices
        for (int pi = 0; pi < 5; pi++) begin
            for (int fs = 0; fs < 2; fs++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    do_read(1'((pi + sz) % 2), 24'(pi * 24'h10203 + sz * 24'h57 + fs * 24'h800000),
                            2'(sz), div_set[pi], 1'(fs), 1'b0, 1'b0, 1'b0, '0, 1'b0);
                end
            end
        end

        // address wrap at the top of a window
        do_read(1'b1, 24'hFFFFFE, 2'd2, 7'd2, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);

        // R9: inputs changed while busy must not alter the transfer
        do_read(1'b0, 24'h123456, 2'd2, 7'd2, 1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b0);
        do_read(1'b1, 24'hABCDEF, 2'd1, 7'd4, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0);

        // R9: new request present in the ready cycle, back-to-back pairs
        do_read(1'b0, 24'h000100, 2'd2, 7'd3, 1'b0, 1'b0, 1'b1, 1'b1, 24'h000200, 1'b0);
        do_read(1'b1, 24'h000200, 2'd0, 7'd3, 1'b0, 1'b0, 1'b1, 1'b0, 24'h7FFFF0, 1'b1);
        do_read(1'b0, 24'h7FFFF0, 2'd1, 7'd3, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1);
        do_read(1'b1, 24'h3C3C3C, 2'd2, 7'd1, 1'b1, 1'b0, 1'b1, 1'b1, 24'h3C3C40, 1'b0);
        do_read(1'b1, 24'h3C3C40, 2'd2, 7'd1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b1);

        // R9: with the request dropped the bridge stays deselected
        repeat (60) @(negedge clk);
        #1;
        chk(sf_cs_n == 2'b11, "R9 no spontaneous start", 32'(sf_cs_n), 32'h3);
        chk(!sf_sck, "R4 idle clock low", 32'(sf_sck), 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule